// File: doc/BRIEF.md
# Link Drive-Level Adjustment Engine

This block reads the lane status and adjustment-request bytes that a display sink returns during link training. It reports whether clock recovery has completed on every active lane and whether channel equalization has completed. It also computes the next common drive setting, made of voltage swing, pre-emphasis and two saturation flags. A training controller loads a snapshot, pulses `start`, and receives the verdicts and the new drive byte one `done` pulse later.

The engine examines one lane per clock cycle. A request starts with `start` while the engine is idle and the snapshot is captured in that same cycle. The engine then visits lanes 0 up to the last active lane, keeping a running AND of the lane conditions and a running maximum of the swing and pre-emphasis requests. When it reaches the last lane, it saturates the result against the top swing level and against a pre-emphasis ceiling that depends on the swing. All outputs are then registered together with `done`.

Top module: `link_drive_adjust`

## Requirements
- R1: While reset is held and after reset is released, `done`, `cr_ok` and `eq_ok` are 0, and `train_set` and `lane_set` are all zeros until the first result.
- R2: Each lane has a 4-bit status nibble. Lanes 0 and 1 are in `lane_status[7:0]` and lanes 2 and 3 are in `lane_status[15:8]`, with the odd lane in the upper nibble. Nibble bit 0 means clock recovery is done. `cr_ok` is 1 only if bit 0 is set for every active lane.
- R3: Status and requests of lanes at or above the active lane count have no effect on any output.
- R4: `eq_ok` is 1 only if `align_done` is 1 and nibble bits [2:0] (clock recovery done, equalization done, symbol lock) are all 1 for every active lane.
- R5: Each lane requests a 2-bit swing and a 2-bit pre-emphasis in `adjust_req`. Lanes 0 and 1 use byte [7:0] and lanes 2 and 3 use byte [15:8]. The even lane puts swing in bits [1:0] and pre-emphasis in bits [3:2]. The odd lane puts swing in bits [5:4] and pre-emphasis in bits [7:6]. The chosen swing is the maximum request over the active lanes, and so is the chosen pre-emphasis. `train_set` holds swing in [1:0], pre-emphasis in [4:3] and zeros in [7:6].
- R6: When the chosen swing is at or above `TOP_SWING` (default 3), the swing is clamped to `TOP_SWING` and `train_set[2]` is set. Otherwise `train_set[2]` is 0.
- R7: The pre-emphasis ceiling is 2 for swing 0 or 1, 1 for swing 2 and 0 for swing 3, taken on the clamped swing. When the chosen pre-emphasis is at or above the ceiling, it is clamped to the ceiling and `train_set[5]` is set. Otherwise `train_set[5]` is 0.
- R8: `lane_set` carries `train_set` in each of its four byte slots.
- R9: `done` is a one-cycle pulse. It rises N clock edges after the edge that accepts `start`, where N is the number of active lanes. `cr_ok`, `eq_ok`, `train_set` and `lane_set` change only in the cycle in which `done` is 1.
- R10: A `lane_cnt` of 1 or 2 selects that many lanes. Any other value selects 4 lanes.
- R11: A `start` pulse that arrives while a request is in progress is ignored: it produces no extra `done` and does not change the pending result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin evaluating the presented snapshot |
| lane_status | input | 16 | Per-lane status nibbles, four lanes |
| align_done | input | 1 | Interlane alignment complete flag |
| adjust_req | input | 16 | Per-lane swing and pre-emphasis requests |
| lane_cnt | input | 3 | Active lane count |
| cr_ok | output | 1 | Clock recovery complete on all active lanes |
| eq_ok | output | 1 | Channel equalization complete |
| train_set | output | 8 | Common drive setting with saturation flags |
| lane_set | output | 32 | The drive setting repeated for four lanes |
| done | output | 1 | Result valid pulse |

## Verification
The bench builds the engine with the default `TOP_SWING` of 3. With that value all four swing codes can be requested, so both saturation paths are exercised. At swing 3 the ceiling is zero, so pre-emphasis saturates on every request. At swings 0, 1 and 2 the request can fall below or reach the ceiling. Directed snapshots place faulty lanes just inside and just outside the active lane count. A pseudo-random sweep covers all lane-count codes, including the ones that fall back to four lanes.

// File: rtl/link_drive_adjust.sv
module link_drive_adjust #(
  parameter logic [1:0] TOP_SWING = 2'd3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] lane_status,
  input  logic        align_done,
  input  logic [15:0] adjust_req,
  input  logic [2:0]  lane_cnt,
  output logic        cr_ok,
  output logic        eq_ok,
  output logic [7:0]  train_set,
  output logic [31:0] lane_set,
  output logic        done
);

  logic        busy;
  logic [1:0]  idx, last;
  logic [15:0] st_q, adj_q;
  logic        cr_acc, eq_acc;
  logic [1:0]  v_acc, p_acc;

  logic [7:0] st_byte, adj_byte;
  logic [3:0] nib;
  logic [1:0] lane_v, lane_p, v_n, p_n, v_f, p_f, ceil_p;
  logic       cr_n, eq_n, sw_max, pe_max;

  assign st_byte  = idx[1] ? st_q[15:8]  : st_q[7:0];
  assign adj_byte = idx[1] ? adj_q[15:8] : adj_q[7:0];
  assign nib      = idx[0] ? st_byte[7:4]  : st_byte[3:0];
  assign lane_v   = idx[0] ? adj_byte[5:4] : adj_byte[1:0];
  assign lane_p   = idx[0] ? adj_byte[7:6] : adj_byte[3:2];

  assign cr_n = cr_acc & nib[0];
  assign eq_n = eq_acc & (&nib[2:0]);
  assign v_n  = (lane_v > v_acc) ? lane_v : v_acc;
  assign p_n  = (lane_p > p_acc) ? lane_p : p_acc;

  assign sw_max = (v_n >= TOP_SWING);
  assign v_f    = sw_max ? TOP_SWING : v_n;

  always_comb begin
    case (v_f)
      2'd0, 2'd1: ceil_p = 2'd2;
      2'd2:       ceil_p = 2'd1;
      default:    ceil_p = 2'd0;
    endcase
  end

  assign pe_max = (p_n >= ceil_p);
  assign p_f    = pe_max ? ceil_p : p_n;

  assign lane_set = {4{train_set}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      idx       <= '0;
      last      <= '0;
      st_q      <= '0;
      adj_q     <= '0;
      cr_acc    <= 1'b0;
      eq_acc    <= 1'b0;
      v_acc     <= '0;
      p_acc     <= '0;
      cr_ok     <= 1'b0;
      eq_ok     <= 1'b0;
      train_set <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          idx    <= '0;
          last   <= (lane_cnt == 3'd1) ? 2'd0 : (lane_cnt == 3'd2) ? 2'd1 : 2'd3;
          st_q   <= lane_status;
          adj_q  <= adjust_req;
          cr_acc <= 1'b1;
          eq_acc <= align_done;
          v_acc  <= '0;
          p_acc  <= '0;
        end
      end else begin
        cr_acc <= cr_n;
        eq_acc <= eq_n;
        v_acc  <= v_n;
        p_acc  <= p_n;
        idx    <= idx + 2'd1;
        if (idx == last) begin
          busy      <= 1'b0;
          done      <= 1'b1;
          cr_ok     <= cr_n;
          eq_ok     <= eq_n;
          train_set <= {2'b00, pe_max, p_f, sw_max, v_f};
        end
      end
    end
  end

endmodule

// File: rtl/link_drive_adjust_chk.sv
module link_drive_adjust_chk #(
  parameter logic [1:0] TOP_SWING = 2'd3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       done,
  input logic       cr_ok,
  input logic       eq_ok,
  input logic [7:0] train_set
);

  logic [1:0] ceil_c;
  always_comb begin
    case (train_set[1:0])
      2'd0, 2'd1: ceil_c = 2'd2;
      2'd2:       ceil_c = 2'd1;
      default:    ceil_c = 2'd0;
    endcase
  end

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({cr_ok, eq_ok, train_set}));

  a_r4_eq_implies_cr: assert property (@(posedge clk) disable iff (!rst_n)
    eq_ok |-> cr_ok);

  a_r6_swing_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (train_set[2] == (train_set[1:0] == TOP_SWING)));

  a_r7_pre_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (train_set[4:3] <= ceil_c) && (train_set[5] == (train_set[4:3] == ceil_c)));

endmodule

bind link_drive_adjust link_drive_adjust_chk #(.TOP_SWING(TOP_SWING)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .cr_ok(cr_ok), .eq_ok(eq_ok), .train_set(train_set)
);

// File: tb/link_drive_adjust_test.sv
module link_drive_adjust_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] lane_status = '0;
  logic        align_done = 1'b0;
  logic [15:0] adjust_req = '0;
  logic [2:0]  lane_cnt = 3'd4;
  logic        cr_ok, eq_ok, done;
  logic [7:0]  train_set;
  logic [31:0] lane_set;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  logic [13:0] exp_q[$];
  int          scyc_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  link_drive_adjust uut (
    .clk(clk), .rst_n(rst_n), .start(start), .lane_status(lane_status),
    .align_done(align_done), .adjust_req(adjust_req), .lane_cnt(lane_cnt),
    .cr_ok(cr_ok), .eq_ok(eq_ok), .train_set(train_set), .lane_set(lane_set), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [13:0] model(input logic [15:0] st, input logic al,
                                        input logic [15:0] adj, input logic [2:0] c);
    int n;
    logic cr, eq;
    logic [1:0] v, p, ceil, lv, lp;
    logic [3:0] nb;
    logic [7:0] a;
    logic vf, pf;
    n = (c == 3'd1) ? 1 : (c == 3'd2) ? 2 : 4;
    cr = 1'b1; eq = al; v = 0; p = 0;
    for (int l = 0; l < n; l++) begin
      nb = st[4*l +: 4];
      a  = adj[8*(l/2) +: 8];
      lv = a[4*(l%2) +: 2];
      lp = a[4*(l%2)+2 +: 2];
      if (!nb[0]) cr = 1'b0;
      if (nb[2:0] != 3'b111) eq = 1'b0;
      if (lv > v) v = lv;
      if (lp > p) p = lp;
    end
    vf = (v == 2'd3);
    ceil = (v == 2'd3) ? 2'd0 : (v == 2'd2) ? 2'd1 : 2'd2;
    pf = (p >= ceil);
    if (pf) p = ceil;
    model = {n[3:0], cr, eq, 2'b00, pf, p, vf, v};
  endfunction

  task automatic drive(input logic [15:0] st, input logic al, input logic [15:0] adj,
                       input logic [2:0] c, input string tag);
    @(negedge clk);
    lane_status = st; align_done = al; adjust_req = adj; lane_cnt = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    exp_q.push_back(model(st, al, adj, c));
    scyc_q.push_back(cyc);
    tag_q.push_back(tag);
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected done", 32'd1, 32'd0);
      end else begin
        logic [13:0] e;
        int s;
        string t;
        e = exp_q.pop_front(); s = scyc_q.pop_front(); t = tag_q.pop_front();
        check((cyc - s) == int'(e[13:10]), {"R9 latency ", t}, cyc - s, e[13:10]);
        check(cr_ok == e[9], {"R2 cr_ok ", t}, cr_ok, e[9]);
        check(eq_ok == e[8], {"R4 eq_ok ", t}, eq_ok, e[8]);
        check(train_set == e[7:0], {"R5 train_set ", t}, train_set, e[7:0]);
        check(lane_set == {4{e[7:0]}}, {"R8 lane_set ", t}, lane_set, {4{e[7:0]}});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    check({done, cr_ok, eq_ok, train_set} == 11'd0, "R1 in reset", {done, cr_ok, eq_ok, train_set}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({done, cr_ok, eq_ok, train_set} == 11'd0 && lane_set == 0, "R1 after reset",
          {done, cr_ok, eq_ok, train_set}, 0);

    drive(16'h0007, 1'b1, 16'h0000, 3'd1, "R2 one lane good");
    drive(16'h0007, 1'b1, 16'h0000, 3'd2, "R2 lane1 missing");
    drive(16'h0777, 1'b1, 16'hFFF0, 3'd2, "R3 upper lanes ignored");
    drive(16'h0777, 1'b1, 16'h0000, 3'd4, "R2 lane3 missing");
    drive(16'h7777, 1'b0, 16'h0000, 3'd4, "R4 align clear");
    drive(16'h7377, 1'b1, 16'h0000, 3'd4, "R4 lane2 no lock");
    drive(16'h7777, 1'b1, 16'h0300, 3'd4, "R6 swing top lane2");
    drive(16'h1111, 1'b0, 16'h000E, 3'd1, "R7 swing2 pre3 clamp");
    drive(16'h1111, 1'b0, 16'h4010, 3'd4, "R5 max over lanes");
    drive(16'h1111, 1'b0, 16'h0008, 3'd1, "R7 swing0 pre2 ceiling");
    drive(16'h1111, 1'b0, 16'h0005, 3'd2, "R5 below ceiling");
    drive(16'h0117, 1'b1, 16'h0000, 3'd0, "R10 count0 as four");
    drive(16'h1111, 1'b0, 16'h3000, 3'd7, "R10 count7 as four");

    @(negedge clk);
    lane_status = 16'h7777; align_done = 1'b1; adjust_req = 16'h0021; lane_cnt = 3'd4; start = 1'b1;
    @(negedge clk);
    exp_q.push_back(model(16'h7777, 1'b1, 16'h0021, 3'd4));
    scyc_q.push_back(cyc);
    tag_q.push_back("R11 start while busy");
    lane_status = 16'h0000; align_done = 1'b0; adjust_req = 16'hFFFF; lane_cnt = 3'd1;
    @(negedge clk);
    start = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);

    lf = 32'h1ACE_5EED;
    for (int k = 0; k < 40; k++) begin
      lf = lf * 32'd1664525 + 32'd1013904223;
      drive(lf[31:16] | 16'h1111, lf[3], lf[15:0] ^ lf[27:12], lf[6:4], "R10 sweep");
    end

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule